// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block drives SCL and SDA as the transmitting master of a two-wire bus. A host writes four small registers over a simple synchronous write port: a command register, a clock setup register, a control register and a data register. When the interface is enabled and the bus is free, the host loads the first byte and writes the start command. The block then produces the START condition and shifts out that byte. The first byte is normally the 7-bit target address in bits [7:1] with the read/write bit in bit 0, where 0 means write. The block does not interpret these bits; it sends them as they are.

After each byte the block parks SCL low and raises a one-cycle done pulse. Each later write to the data register sends one more byte, with its clocks generated automatically. The stop command ends the transfer with a STOP condition. A bus-busy flag is high from the start command until the STOP has completed. The clock setup register selects one of two SCL speeds. It also selects whether a ninth clock is generated, in which the SDA level returned by the slave is latched into a last-received-bit flag.

Each bit period is split into four quarter periods, and every quarter lasts a parameterised number of system clocks. SDA changes only in the second quarter, while SCL is low. START and STOP are the only exceptions.

Top module: `i2cm_tx`

## Requirements
- R1: After reset, and whenever `bus_busy` is 0, `scl_out` and `sda_out` are both 1. After reset `last_rx_bit` is 1 and `byte_done` is 0.
- R2: Writing 0xF0 to address 0 while control bit 3 (address 2) is set and `bus_busy` is 0 does three things. It sets `bus_busy`. It drives SDA low while SCL is still high. It then sends the byte held in the data register (address 3) MSB first, with each bit valid at the SCL rising edge.
- R3: A write of 0xF0 is ignored while `bus_busy` is 1 or while control bit 3 is clear: no SCL pulse and no change of `bus_busy`.
- R4: During a byte, SDA changes only while SCL is low. SDA falls with SCL high only in the START sequence, and rises with SCL high only in the STOP sequence.
- R5: With clock setup bit 7 (address 1) set, each byte has a ninth clock. In that clock the master releases SDA, and the SDA input level sampled during SCL high is stored in `last_rx_bit` (0 means acknowledged). With bit 7 clear, each byte has exactly 8 clocks and `last_rx_bit` keeps its value.
- R6: The SCL period is 4·QTR_STD system clocks when clock setup bit 5 is clear, and 4·QTR_FAST when it is set.
- R7: After the last clock of each byte, `byte_done` is high for exactly one cycle. SCL then stays low, and no further clocks come until the next command or data write.
- R8: A data register write while a transfer is parked after a byte sends that new byte, with its clocks, without any further command.
- R9: A data register write while a byte is being shifted is ignored. The byte on the wire is unchanged and no extra byte follows it.
- R10: Writing 0xD0 while parked drives SDA low, then SCL high, then SDA high, and then clears `bus_busy`. Writing 0xD0 while the bus is idle has no effect on the lines.
- R11: Command values other than 0xF0 and 0xD0 (for example 0x00) leave the lines and `bus_busy` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 command, 1 clock setup, 2 control, 3 data |
| wr_data | input | 8 | Register write value |
| sda_in | input | 1 | Level seen on the SDA wire |
| scl_out | output | 1 | SCL level driven by the master |
| sda_out | output | 1 | SDA level driven by the master (1 = released) |
| bus_busy | output | 1 | High from START command until STOP completes |
| last_rx_bit | output | 1 | SDA level captured in the ninth clock |
| byte_done | output | 1 | One-cycle pulse after each byte |

## Verification
The assertions assume that no other master is on the bus. They also assume that `sda_in` is only the wired-AND of `sda_out` and a slave that pulls low during the ninth clock, and that the clock setup register is not rewritten while a byte is in flight. The bench models just such a slave. It changes the clock setup only while the bus is idle or parked. The start, stop and data writes it issues are at points where the protocol allows them, apart from the deliberate out-of-turn writes used to probe R3, R9, R10 and R11.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam logic [1:0] REG_CMD  = 2'd0;
    localparam logic [1:0] REG_CLK  = 2'd1;
    localparam logic [1:0] REG_CTL  = 2'd2;
    localparam logic [1:0] REG_DATA = 2'd3;

    localparam logic [7:0] CMD_START = 8'hF0;
    localparam logic [7:0] CMD_STOP  = 8'hD0;

    localparam int CLK_ACK_BIT  = 7;
    localparam int CLK_FAST_BIT = 5;
    localparam int CTL_EN_BIT   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_HOLD,
        ST_STOP
    } seq_state_e;

    typedef struct packed {
        logic ack_clk;
        logic fast;
        logic enable;
    } cfg_t;

    typedef struct packed {
        logic       start;
        logic       stop;
        logic       load;
        logic [7:0] data;
    } req_t;

    function automatic logic [3:0] last_bit_idx(input cfg_t c);
        return c.ack_clk ? 4'd8 : 4'd7;
    endfunction

endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output cfg_t       cfg,
    output req_t       req
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_CLK) begin
                cfg_q.ack_clk <= wr_data[CLK_ACK_BIT];
                cfg_q.fast    <= wr_data[CLK_FAST_BIT];
            end
            if (wr_addr == REG_CTL) begin
                cfg_q.enable <= wr_data[CTL_EN_BIT];
            end
        end
    end

    always_comb begin
        req.start = wr_en && (wr_addr == REG_CMD) && (wr_data == CMD_START);
        req.stop  = wr_en && (wr_addr == REG_CMD) && (wr_data == CMD_STOP);
        req.load  = wr_en && (wr_addr == REG_DATA);
        req.data  = wr_data;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int QTR_STD  = 6,
    parameter int QTR_FAST = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic tick
);

    localparam int QMAX = (QTR_STD > QTR_FAST) ? QTR_STD : QTR_FAST;
    localparam int CW   = $clog2(QMAX) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = fast ? CW'(QTR_FAST - 1) : CW'(QTR_STD - 1);
    assign tick = run && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cfg_t       cfg,
    input  req_t       req,
    input  logic       tick,
    input  logic       sda_in,
    output logic       run,
    output logic       scl,
    output logic       sda,
    output logic       busy,
    output logic       ack_bit,
    output logic       done,
    output seq_state_e state_o
);

    seq_state_e state;
    logic [1:0] qtr;
    logic [3:0] bitn;
    logic [7:0] shreg;

    assign run     = (state == ST_START) || (state == ST_BIT) || (state == ST_STOP);
    assign state_o = state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            qtr     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            scl     <= 1'b1;
            sda     <= 1'b1;
            busy    <= 1'b0;
            ack_bit <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req.load) shreg <= req.data;
                    if (req.start && cfg.enable) begin
                        state <= ST_START;
                        qtr   <= 2'd0;
                        busy  <= 1'b1;
                    end
                end
                ST_START: if (tick) begin
                    if (qtr == 2'd0) begin
                        sda <= 1'b0;
                        qtr <= 2'd1;
                    end else begin
                        scl   <= 1'b0;
                        qtr   <= 2'd0;
                        bitn  <= '0;
                        state <= ST_BIT;
                    end
                end
                ST_BIT: if (tick) begin
                    unique case (qtr)
                        2'd0: begin
                            sda <= (bitn < 4'd8) ? shreg[7] : 1'b1;
                            qtr <= 2'd1;
                        end
                        2'd1: begin
                            scl <= 1'b1;
                            qtr <= 2'd2;
                        end
                        2'd2: begin
                            if (bitn == 4'd8) ack_bit <= sda_in;
                            qtr <= 2'd3;
                        end
                        default: begin
                            scl <= 1'b0;
                            qtr <= 2'd0;
                            if (bitn < 4'd8) shreg <= {shreg[6:0], 1'b0};
                            if (bitn == last_bit_idx(cfg)) begin
                                state <= ST_HOLD;
                                done  <= 1'b1;
                            end else begin
                                bitn <= bitn + 4'd1;
                            end
                        end
                    endcase
                end
                ST_HOLD: begin
                    if (req.load) begin
                        shreg <= req.data;
                        bitn  <= '0;
                        qtr   <= 2'd0;
                        state <= ST_BIT;
                    end else if (req.stop) begin
                        qtr   <= 2'd0;
                        state <= ST_STOP;
                    end
                end
                ST_STOP: if (tick) begin
                    unique case (qtr)
                        2'd0: begin
                            sda <= 1'b0;
                            qtr <= 2'd1;
                        end
                        2'd1: begin
                            scl <= 1'b1;
                            qtr <= 2'd2;
                        end
                        2'd2: begin
                            sda <= 1'b1;
                            qtr <= 2'd3;
                        end
                        default: begin
                            busy  <= 1'b0;
                            qtr   <= 2'd0;
                            state <= ST_IDLE;
                        end
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2cm_tx.sv
module i2cm_tx
    import i2cm_pkg::*;
#(
    parameter int QTR_STD  = 6,
    parameter int QTR_FAST = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       sda_in,
    output logic       scl_out,
    output logic       sda_out,
    output logic       bus_busy,
    output logic       last_rx_bit,
    output logic       byte_done
);

    cfg_t       cfg;
    req_t       req;
    logic       run;
    logic       tick;
    seq_state_e seq_state;

    i2cm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .req     (req)
    );

    i2cm_tick #(
        .QTR_STD  (QTR_STD),
        .QTR_FAST (QTR_FAST)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .fast (cfg.fast),
        .tick (tick)
    );

    i2cm_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .req     (req),
        .tick    (tick),
        .sda_in  (sda_in),
        .run     (run),
        .scl     (scl_out),
        .sda     (sda_out),
        .busy    (bus_busy),
        .ack_bit (last_rx_bit),
        .done    (byte_done),
        .state_o (seq_state)
    );

endmodule

// File: rtl/i2cm_tx_chk.sv
module i2cm_tx_chk
    import i2cm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       scl_out,
    input logic       sda_out,
    input logic       bus_busy,
    input logic       last_rx_bit,
    input logic       byte_done,
    input seq_state_e seq_state
);

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_busy |-> (scl_out && sda_out));

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_busy) |-> $past(wr_en && (wr_addr == REG_CMD) && (wr_data == CMD_START)));

    // R4
    sda_hi_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_out && $past(scl_out) && $fell(sda_out)) |-> (seq_state == ST_START));

    // R4
    sda_hi_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_out && $past(scl_out) && $rose(sda_out)) |-> (seq_state == ST_STOP));

    // R5
    ack_sample_chk: assert property (@(posedge clk) disable iff (rst)
        $changed(last_rx_bit) |-> (scl_out && $past(scl_out)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> !byte_done);

    // R7
    done_park_chk: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> (bus_busy && !scl_out));

    // R10
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy) |-> $past(seq_state == ST_STOP));

endmodule

bind i2cm_tx i2cm_tx_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .scl_out     (scl_out),
    .sda_out     (sda_out),
    .bus_busy    (bus_busy),
    .last_rx_bit (last_rx_bit),
    .byte_done   (byte_done),
    .seq_state   (seq_state)
);

// File: tb/i2cm_tx_tb_top.sv
module i2cm_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int QS = 6;
    localparam int QF = 2;
    localparam int TAIL = 4 * QS * 3;

    // {fast, ack clock enable, slave acks, byte}
    localparam logic [10:0] VEC [0:5] = '{
        {1'b0, 1'b1, 1'b1, 8'hA4},
        {1'b1, 1'b0, 1'b0, 8'h5B},
        {1'b1, 1'b1, 1'b0, 8'hC3},
        {1'b0, 1'b1, 1'b1, 8'h01},
        {1'b0, 1'b0, 1'b1, 8'hFE},
        {1'b1, 1'b1, 1'b1, 8'h96}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       slave_low = 1'b0;
    logic       sda_in;
    logic       scl_out, sda_out, bus_busy, last_rx_bit, byte_done;

    int tests = 0;
    int fails = 0;

    logic [7:0] got;
    int rises, period, dones, hi_fall, hi_rise;
    logic scl_end;

    assign sda_in = sda_out & ~slave_low;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2cm_tx #(.QTR_STD(QS), .QTR_FAST(QF)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sda_in      (sda_in),
        .scl_out     (scl_out),
        .sda_out     (sda_out),
        .bus_busy    (bus_busy),
        .last_rx_bit (last_rx_bit),
        .byte_done   (byte_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Observe the bus as a slave would; optionally poke the data register mid-byte.
    task automatic watch(input bit ack_on, input int poke_at, input int cap);
        logic prev_scl = scl_out;
        logic prev_sda = sda_out;
        int c = 0;
        int r1 = 0;
        int tail = -1;
        got = '0; rises = 0; period = 0; dones = 0; hi_fall = 0; hi_rise = 0;
        while (tail != 0 && c < cap) begin
            @(negedge clk);
            c++;
            wr_en   = (c == poke_at);
            wr_addr = 2'd3;
            wr_data = 8'hFF;
            if (scl_out && !prev_scl) begin
                rises++;
                if (rises <= 8) got = {got[6:0], sda_in};
                if (rises == 1) r1 = c;
                if (rises == 2) period = c - r1;
            end
            if (scl_out && prev_scl && (sda_out != prev_sda)) begin
                if (sda_out) hi_rise++;
                else hi_fall++;
            end
            if (byte_done) begin
                dones++;
                if (tail < 0) tail = TAIL;
            end
            if (tail > 0) tail--;
            slave_low = ack_on && (rises == 8 || (rises == 9 && scl_out));
            prev_scl = scl_out;
            prev_sda = sda_out;
        end
        wr_en = 1'b0;
        slave_low = 1'b0;
        scl_end = scl_out;
    endtask

    task automatic stop_seq();
        logic prev_scl;
        logic prev_sda;
        int seen = 0;
        int c = 0;
        wr(2'd0, 8'hD0);
        prev_scl = scl_out;
        prev_sda = sda_out;
        while (bus_busy && c < 400) begin
            @(negedge clk);
            c++;
            if (scl_out && prev_scl && sda_out && !prev_sda) seen++;
            prev_scl = scl_out;
            prev_sda = sda_out;
        end
        chk("R10 stop edge count", seen, 1);
        chk("R10 busy cleared", bus_busy, 0);
        chk("R1 lines high after stop", {scl_out, sda_out}, 2'b11);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic exp_ack;
        logic fast, ackc, sack;
        logic [7:0] data;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 scl/sda idle", {scl_out, sda_out}, 2'b11);
        chk("R1 busy clear", bus_busy, 0);
        chk("R1 last_rx_bit", last_rx_bit, 1);
        chk("R1 byte_done", byte_done, 0);

        // R3 start while disabled
        wr(2'd3, 8'hA5);
        wr(2'd0, 8'hF0);
        watch(1'b0, 0, 60);
        chk("R3 no clocks when disabled", rises, 0);
        chk("R3 busy stays clear when disabled", bus_busy, 0);

        wr(2'd2, 8'h08);
        exp_ack = 1'b1;

        for (int i = 0; i < 6; i++) begin
            {fast, ackc, sack, data} = VEC[i];
            wr(2'd1, {ackc, 1'b0, fast, 5'b00101});
            wr(2'd3, data);
            wr(2'd0, 8'hF0);
            chk("R2 busy after start", bus_busy, 1);
            watch(sack, 0, 4000);
            if (ackc) exp_ack = sack ? 1'b0 : 1'b1;
            chk("R2 byte on wire", got, data);
            chk("R5 clock count", rises, ackc ? 9 : 8);
            chk("R6 scl period", period, 4 * (fast ? QF : QS));
            chk("R7 one done pulse", dones, 1);
            chk("R7 scl parked low", scl_end, 0);
            chk("R4 start fall only", hi_fall, 1);
            chk("R4 no high rise in byte", hi_rise, 0);
            chk("R5 last_rx_bit", last_rx_bit, exp_ack);
            stop_seq();
        end

        // R9 data write mid-byte ignored
        wr(2'd1, 8'h85);
        wr(2'd3, 8'h81);
        wr(2'd0, 8'hF0);
        watch(1'b1, 30, 4000);
        chk("R9 byte unchanged", got, 8'h81);
        chk("R9 no extra byte", rises, 9);
        chk("R9 one done", dones, 1);

        // R3 start while busy
        wr(2'd0, 8'hF0);
        watch(1'b0, 0, 60);
        chk("R3 no clocks when busy", rises, 0);
        chk("R3 no start edge when busy", hi_fall, 0);
        chk("R3 still parked", {bus_busy, scl_out}, 2'b10);

        // R11 other command value
        wr(2'd0, 8'h00);
        watch(1'b0, 0, 60);
        chk("R11 no clocks", rises, 0);
        chk("R11 still parked", {bus_busy, scl_out}, 2'b10);

        // R8 next byte from parked state
        wr(2'd3, 8'h3C);
        watch(1'b0, 0, 4000);
        chk("R8 next byte", got, 8'h3C);
        chk("R8 clocks", rises, 9);
        chk("R8 done", dones, 1);
        chk("R8 no start edge", hi_fall, 0);
        chk("R5 nack latched", last_rx_bit, 1);
        stop_seq();

        // R10 stop while idle
        wr(2'd0, 8'hD0);
        watch(1'b0, 0, 60);
        chk("R10 idle stop no edge", hi_rise + hi_fall + rises, 0);
        chk("R10 idle lines", {bus_busy, scl_out, sda_out}, 3'b011);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule